// File: doc/BRIEF.md
# DMA Channel Event Flag and Interrupt Unit

This block sits beside the channel engines of a seven-channel DMA controller. Each channel reports three kinds of event as single-cycle pulses: reaching the halfway point of a transfer, finishing a transfer, and hitting a transfer error. The block latches each pulse into a sticky flag. It derives a per-channel summary flag that is set whenever any of the three flags is set. It drives one interrupt line per channel from the flags whose enable inputs are high.

Software reaches the flags through a 32-bit word-only register window that holds two registers. A read-only status word packs four bits per channel. A write-only clear word takes a 1 in any bit to drop the matching flag. Each channel carries a privilege attribute, and each bus access carries one too. An unprivileged access can neither see nor clear the flags of a privileged channel.

Top module: `dma_irq_status`

## Requirements
- R1: After reset every flag is zero, a privileged status read returns 0 and every interrupt output is low.
- R2: An event pulse sets its flag whatever the enable inputs are. The flag stays set until it is cleared by software.
- R3: The status word (offset 0x0) gives channel c (0-based) bits 4c+3:4c. Bit 4c is the summary flag, which is the OR of the other three. Bit 4c+1 is transfer done, bit 4c+2 is half transfer and bit 4c+3 is error. Bits 31:28 read as zero.
- R4: irq[c] is high exactly when at least one of channel c's done, half and error flags is set with its matching enable input high.
- R5: A word write to the clear register (offset 0x4) with bit 4c+1, 4c+2 or 4c+3 set clears that single flag. A bit written as 0 leaves its flag unchanged.
- R6: Writing 1 to bit 4c of the clear register clears all of channel c's flags at once.
- R7: When ch_priv[c] is 1, a clear write affects channel c only if bus_priv is 1. Otherwise channel c's flags are unchanged.
- R8: An unprivileged status read returns zero in the nibble of every channel with ch_priv[c]=1, and the true nibble for the other channels. A privileged read returns all nibbles.
- R9: Only accesses with bus_size = 2 (word) act. A byte (0) or halfword (1) write changes nothing, and a byte or halfword read returns 0. Writes to the status register have no effect. Reads of the clear register return 0.
- R10: If an event pulse and a clear of the same flag occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_done | input | 7 | Per-channel transfer-complete pulse |
| ev_half | input | 7 | Per-channel half-transfer pulse |
| ev_err | input | 7 | Per-channel transfer-error pulse |
| ie_done | input | 7 | Per-channel interrupt enable for the done flag |
| ie_half | input | 7 | Per-channel interrupt enable for the half flag |
| ie_err | input | 7 | Per-channel interrupt enable for the error flag |
| ch_priv | input | 7 | Per-channel privileged-mode attribute |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the access |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_priv | input | 1 | Privilege attribute of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while the read is presented |
| irq | output | 7 | Per-channel interrupt request |

## Verification
The bench builds the block with its default parameters: seven channels, a 32-bit word and a 4-bit offset. With these values the whole flag space is small enough to sweep. Every channel and every event kind is raised one at a time. For each raised flag, all eight enable combinations are applied and the matching single-bit clear is checked. A mixed privilege pattern is then set on the channels to test read masking and clear gating against a bench-side flag model. Halfword and byte accesses, writes to the status word, and a set that collides with a clear in the same cycle are checked against the same model.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   localparam int NIB_W    = 4;
   localparam int NIB_SUM  = 0;
   localparam int NIB_DONE = 1;
   localparam int NIB_HALF = 2;
   localparam int NIB_ERR  = 3;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   typedef struct packed {
      logic err;
      logic half;
      logic done;
   } ch_flags_t;
endpackage

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
   import dma_irq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  ch_flags_t       set_i,
   input  ch_flags_t       clr_i,
   input  ch_flags_t       en_i,
   output logic [NIB_W-1:0] nibble_o,
   output logic            irq_o
);
   ch_flags_t flg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flg_q <= '0;
      end else begin
         flg_q <= set_i | (flg_q & ~clr_i);
      end
   end

   always_comb begin
      nibble_o           = '0;
      nibble_o[NIB_SUM]  = |flg_q;
      nibble_o[NIB_DONE] = flg_q.done;
      nibble_o[NIB_HALF] = flg_q.half;
      nibble_o[NIB_ERR]  = flg_q.err;
   end

   assign irq_o = |(flg_q & en_i);

   // R2 / R10: a pulse always leaves its flag set, even against a clear
   assert_set_sticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i.done |=> nibble_o[NIB_DONE]);
   assert_set_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i.half |=> nibble_o[NIB_HALF]);
   // R5: a clear with no competing pulse drops the flag
   assert_clear_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i.err && !set_i.err) |=> !nibble_o[NIB_ERR]);
endmodule

// File: rtl/dma_irq_regif.sv
module dma_irq_regif
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH     = 7,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int STATUS_OFS = 0,
   parameter int CLEAR_OFS  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_sel,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [1:0]              bus_size,
   input  logic                    bus_priv,
   input  logic [DATA_W-1:0]       bus_wdata,
   input  logic [NUM_CH-1:0]       ch_priv,
   input  logic [NUM_CH*NIB_W-1:0] status_raw,
   output logic [NUM_CH*NIB_W-1:0] clr_vec,
   output logic [DATA_W-1:0]       bus_rdata
);
   localparam int USED_W = NUM_CH * NIB_W;

   logic word_ok, rd_status, wr_clear;
   logic [DATA_W-1:0] visible;

   assign word_ok   = (bus_size == SZ_WORD);
   assign rd_status = bus_sel && !bus_wr && word_ok
                      && (bus_addr == ADDR_W'(STATUS_OFS));
   assign wr_clear  = bus_sel && bus_wr && word_ok
                      && (bus_addr == ADDR_W'(CLEAR_OFS));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic may_touch;
      assign may_touch = bus_priv || !ch_priv[c];
      assign clr_vec[c*NIB_W +: NIB_W] =
         (wr_clear && may_touch) ? bus_wdata[c*NIB_W +: NIB_W] : '0;
      assign visible[c*NIB_W +: NIB_W] =
         may_touch ? status_raw[c*NIB_W +: NIB_W] : '0;
   end

   if (USED_W < DATA_W) begin : g_pad
      logic unused_wdata_hi;
      assign visible[DATA_W-1:USED_W] = '0;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:USED_W];
   end

   assign bus_rdata = rd_status ? visible : '0;

   // R3: reserved bits above the last channel read zero
   assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:USED_W] == '0);
   // R9: non-word accesses neither clear nor return data
   assert_nonword_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_size != SZ_WORD) |-> (clr_vec == '0 && bus_rdata == '0));
   // R7: an unprivileged write never produces a clear for a privileged channel
   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      assert_priv_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!bus_priv && ch_priv[c]) |-> clr_vec[c*NIB_W +: NIB_W] == '0);
   end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH     = 7,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int STATUS_OFS = 0,
   parameter int CLEAR_OFS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ev_done,
   input  logic [NUM_CH-1:0] ev_half,
   input  logic [NUM_CH-1:0] ev_err,
   input  logic [NUM_CH-1:0] ie_done,
   input  logic [NUM_CH-1:0] ie_half,
   input  logic [NUM_CH-1:0] ie_err,
   input  logic [NUM_CH-1:0] ch_priv,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic              bus_priv,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] irq
);
   localparam int USED_W = NUM_CH * NIB_W;

   if (NUM_CH < 1 || USED_W > DATA_W) begin : g_bad_ch
      $error("dma_irq_status: NUM_CH*4 must fit in DATA_W");
   end
   if (STATUS_OFS == CLEAR_OFS || (1 << ADDR_W) <= CLEAR_OFS
       || (1 << ADDR_W) <= STATUS_OFS) begin : g_bad_ofs
      $error("dma_irq_status: register offsets must differ and fit ADDR_W");
   end

   logic [USED_W-1:0] status_raw;
   logic [USED_W-1:0] clr_vec;

   dma_irq_regif #(
      .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .STATUS_OFS(STATUS_OFS), .CLEAR_OFS(CLEAR_OFS)
   ) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_size  (bus_size),
      .bus_priv  (bus_priv),
      .bus_wdata (bus_wdata),
      .ch_priv   (ch_priv),
      .status_raw(status_raw),
      .clr_vec   (clr_vec),
      .bus_rdata (bus_rdata)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ch_flags_t set_s, clr_s, en_s;
      logic [NIB_W-1:0] cn;
      logic             cg;

      assign cn = clr_vec[c*NIB_W +: NIB_W];
      assign cg = cn[NIB_SUM];
      assign set_s = '{err: ev_err[c], half: ev_half[c], done: ev_done[c]};
      assign en_s  = '{err: ie_err[c], half: ie_half[c], done: ie_done[c]};
      assign clr_s = '{err:  cn[NIB_ERR]  | cg,
                       half: cn[NIB_HALF] | cg,
                       done: cn[NIB_DONE] | cg};

      dma_irq_chan u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_i   (set_s),
         .clr_i   (clr_s),
         .en_i    (en_s),
         .nibble_o(status_raw[c*NIB_W +: NIB_W]),
         .irq_o   (irq[c])
      );

      // R4: no interrupt without a stored event on the channel
      assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
         irq[c] |-> status_raw[c*NIB_W + NIB_SUM]);
      // R6: a global clear from a permitted write empties the channel
      assert_global_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (cg && !ev_done[c] && !ev_half[c] && !ev_err[c])
         |=> status_raw[c*NIB_W +: NIB_W] == '0);
      // R7: an unprivileged write leaves a privileged channel's flags set
      assert_priv_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && bus_wr && !bus_priv && ch_priv[c]
          && status_raw[c*NIB_W + NIB_DONE]) |=> status_raw[c*NIB_W + NIB_DONE]);
   end
endmodule

// File: tb/tb_dma_irq_status.sv
module tb_dma_irq_status;
   localparam int NCH = 7;

   logic clk = 0;
   logic rst_n = 0;
   logic [NCH-1:0] ev_done = '0, ev_half = '0, ev_err = '0;
   logic [NCH-1:0] ie_done = '0, ie_half = '0, ie_err = '0;
   logic [NCH-1:0] ch_priv = '0;
   logic           bus_sel = 0, bus_wr = 0, bus_priv = 0;
   logic [3:0]     bus_addr = '0;
   logic [1:0]     bus_size = 2'd2;
   logic [31:0]    bus_wdata = '0;
   logic [31:0]    bus_rdata;
   logic [NCH-1:0] irq;

   int n_run = 0, n_fail = 0;
   bit finished = 0;
   logic [2:0] mf [NCH];   // [0]=done [1]=half [2]=err

   always #4 clk = ~clk;

   dma_irq_status dut (
      .clk(clk), .rst_n(rst_n),
      .ev_done(ev_done), .ev_half(ev_half), .ev_err(ev_err),
      .ie_done(ie_done), .ie_half(ie_half), .ie_err(ie_err),
      .ch_priv(ch_priv),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_size(bus_size), .bus_priv(bus_priv), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic logic [31:0] exp_stat(input logic p);
      logic [31:0] r = '0;
      for (int c = 0; c < NCH; c++)
         if (p || !ch_priv[c])
            r[4*c +: 4] = {mf[c][2], mf[c][1], mf[c][0], |mf[c]};
      return r;
   endfunction

   function automatic logic [NCH-1:0] exp_irq();
      logic [NCH-1:0] r;
      for (int c = 0; c < NCH; c++)
         r[c] = |(mf[c] & {ie_err[c], ie_half[c], ie_done[c]});
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, input logic [1:0] sz, input logic p,
                     output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a; bus_size = sz; bus_priv = p;
      #1 d = bus_rdata;
      bus_sel = 0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic p,
                     input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_size = sz; bus_priv = p;
      bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; bus_wdata = '0;
   endtask

   task automatic model_clear(input logic p, input logic [31:0] d);
      for (int c = 0; c < NCH; c++)
         if (p || !ch_priv[c]) begin
            if (d[4*c]) mf[c] = '0;
            else mf[c] = mf[c] & ~d[4*c+1 +: 3];
         end
   endtask

   task automatic pulse(input int c, input int k);
      @(negedge clk);
      case (k)
         0: ev_done[c] = 1;
         1: ev_half[c] = 1;
         default: ev_err[c] = 1;
      endcase
      @(negedge clk);
      ev_done = '0; ev_half = '0; ev_err = '0;
      mf[c][k] = 1'b1;
   endtask

   task automatic chk_stat(input string tag, input logic p);
      logic [31:0] d;
      rd(4'h0, 2'd2, p, d);
      chk(tag, d, exp_stat(p));
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      for (int c = 0; c < NCH; c++) mf[c] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset state
      chk_stat("R1 status after reset", 1'b1);
      chk("R1 irq after reset", 32'(irq), 32'h0);

      // R2 R3 R4 R5: sweep every channel and event kind
      for (int c = 0; c < NCH; c++) begin
         for (int k = 0; k < 3; k++) begin
            pulse(c, k);
            repeat (2) @(negedge clk);
            chk_stat("R2 R3 flag set and placed", 1'b1);
            for (int e = 0; e < 8; e++) begin
               @(negedge clk);
               ie_done = {NCH{e[0]}}; ie_half = {NCH{e[1]}}; ie_err = {NCH{e[2]}};
               #1 chk("R4 irq vs enables", 32'(irq), 32'(exp_irq()));
            end
            ie_done = '0; ie_half = '0; ie_err = '0;
            wr(4'h4, 2'd2, 1'b1, 32'h0);
            chk_stat("R5 zero write keeps flags", 1'b1);
            wr(4'h4, 2'd2, 1'b1, 32'(1) << (4*c + k + 1));
            model_clear(1'b1, 32'(1) << (4*c + k + 1));
            chk_stat("R5 single clear", 1'b1);
         end
      end

      // R5: clearing one flag leaves the other two
      pulse(3, 0); pulse(3, 1); pulse(3, 2);
      wr(4'h4, 2'd2, 1'b1, 32'h1 << 14);
      model_clear(1'b1, 32'h1 << 14);
      chk_stat("R5 only half cleared", 1'b1);

      // R6: global clear
      pulse(3, 1);
      wr(4'h4, 2'd2, 1'b1, 32'h1 << 12);
      model_clear(1'b1, 32'h1 << 12);
      chk_stat("R6 global clear", 1'b1);

      // R7 R8: mixed privilege pattern
      ch_priv = 7'b1010101;
      for (int c = 0; c < NCH; c++) for (int k = 0; k < 3; k++) pulse(c, k);
      chk_stat("R8 privileged read sees all", 1'b1);
      chk_stat("R8 unprivileged read masked", 1'b0);
      wr(4'h4, 2'd2, 1'b0, 32'h0FFF_FFFF);
      model_clear(1'b0, 32'h0FFF_FFFF);
      chk_stat("R7 unprivileged clear spares privileged", 1'b1);
      wr(4'h4, 2'd2, 1'b1, 32'h0111_1111);
      model_clear(1'b1, 32'h0111_1111);
      chk_stat("R7 privileged clear", 1'b1);
      ch_priv = '0;

      // R9: non-word and wrong-register accesses
      pulse(0, 0); pulse(5, 2);
      wr(4'h4, 2'd1, 1'b1, 32'hFFFF_FFFF);
      chk_stat("R9 halfword clear ignored", 1'b1);
      wr(4'h4, 2'd0, 1'b1, 32'hFFFF_FFFF);
      chk_stat("R9 byte clear ignored", 1'b1);
      wr(4'h0, 2'd2, 1'b1, 32'hFFFF_FFFF);
      chk_stat("R9 status write ignored", 1'b1);
      rd(4'h0, 2'd0, 1'b1, d);
      chk("R9 byte read zero", d, 32'h0);
      rd(4'h0, 2'd1, 1'b1, d);
      chk("R9 halfword read zero", d, 32'h0);
      rd(4'h4, 2'd2, 1'b1, d);
      chk("R9 clear register reads zero", d, 32'h0);

      // R10: set and clear of the same flag in one cycle
      wr(4'h4, 2'd2, 1'b1, 32'h0FFF_FFFF);
      model_clear(1'b1, 32'h0FFF_FFFF);
      @(negedge clk);
      ev_half[2] = 1;
      bus_sel = 1; bus_wr = 1; bus_addr = 4'h4; bus_size = 2'd2; bus_priv = 1;
      bus_wdata = 32'h1 << 10;
      @(negedge clk);
      ev_half = '0; bus_sel = 0; bus_wr = 0; bus_wdata = '0;
      mf[2][1] = 1'b1;
      chk_stat("R10 set wins over single clear", 1'b1);
      pulse(4, 1);
      @(negedge clk);
      ev_done[4] = 1;
      bus_sel = 1; bus_wr = 1; bus_addr = 4'h4; bus_size = 2'd2; bus_priv = 1;
      bus_wdata = 32'h1 << 16;
      @(negedge clk);
      ev_done = '0; bus_sel = 0; bus_wr = 0; bus_wdata = '0;
      mf[4] = 3'b001;
      chk_stat("R10 set wins over global clear", 1'b1);

      finish_run();
   end
endmodule